// File: doc/BRIEF.md
# GPIO Pin Interrupt Controller

This block watches the twelve input pins of one general-purpose I/O port and raises interrupts when they meet programmable trigger conditions. Each pin is set up on its own. It can sense an edge or a level. One polarity bit picks the active direction: a falling edge or low level, or a rising edge or high level. The bit's meaning follows the pin's sense setting.

Every pin has a raw status bit. This bit records that the trigger condition was met, before any masking. A per-pin enable mask gates the raw status onto two places: a dedicated interrupt output for that pin, and one combined port interrupt line. In edge mode a detected edge stays latched until software clears it through a write-one-to-clear register. In level mode the raw status tracks the pin's active level.

Software reaches the block through a simple 32-bit register bus with address, write enable, write data and read data. Read data comes back one clock after the address is presented. Pin inputs are asynchronous and pass through a two-flop synchronizer before detection.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, the sense-mode (offset 0x04), polarity (0x0C), mask (0x10), raw status (0x14) and masked status (0x18) registers all read zero, and `pin_irq` and `port_irq` are low.
- R2: In each register, bits 11:0 map to pins 0 to 11. Sense-mode, polarity and mask are read/write. Bits 31:12 of every register read zero, and writes to those bits are ignored.
- R3: The raw status and masked status registers are read-only. A write to offset 0x14 or 0x18 changes no state.
- R4: In edge mode (sense bit 0), a polarity bit of 1 sets the raw status on a rising edge of the synchronized pin. A polarity bit of 0 sets it on a falling edge. An edge in the other direction leaves it unchanged.
- R5: In edge mode, a set raw status bit stays set after the pin returns, until a 1 is written to that bit of the clear register at offset 0x1C. Bits written as 0 keep their state.
- R6: In level mode (sense bit 1), the raw status is 1 exactly while the synchronized pin equals the polarity bit (1 = high, 0 = low). A clear write has no lasting effect while the level is active.
- R7: `pin_irq[i]` equals the registered AND of raw status bit i and mask bit i. A mask bit of 0 forces it low. Offset 0x18 reads raw status AND mask.
- R8: `port_irq` is high exactly when any bit of `pin_irq` is high.
- R9: Suppose a pin change is first captured at clock edge k. Then the raw status updates at edge k+2, and `pin_irq`/`port_irq` update at edge k+3.
- R10: If a clear write and a new qualifying edge hit the same edge-mode pin in the same cycle, the edge wins and the raw status bit stays set.
- R11: `bus_rdata` shows the register addressed in the previous cycle. The clear register and unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 12 | Asynchronous pin levels |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the address |
| pin_irq | output | 12 | Per-pin masked interrupts |
| port_irq | output | 1 | OR of all per-pin interrupts |

## Verification
The assertions assume three things. First, `bus_addr` and `bus_we` are held at defined values from the first clock. Second, `rst` is held for at least one edge. Third, the pins are held low through reset, so no edge appears from the synchronizer's reset value. The bench drives every input on the falling clock edge and keeps the pins low during reset. For the clear-versus-edge race, it times the clear write so that it lands exactly in the cycle where the edge reaches the detector.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] OFF_SENSE = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_POL   = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_MASK  = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_RAW   = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_MSTAT = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_CLR   = 8'h1C;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_SENSE, SEL_POL, SEL_MASK, SEL_RAW, SEL_MSTAT, SEL_CLR
  } reg_sel_e;

  function automatic reg_sel_e decode_off(input logic [ADDR_W-1:0] a);
    case (a)
      OFF_SENSE: return SEL_SENSE;
      OFF_POL:   return SEL_POL;
      OFF_MASK:  return SEL_MASK;
      OFF_RAW:   return SEL_RAW;
      OFF_MSTAT: return SEL_MSTAT;
      OFF_CLR:   return SEL_CLR;
      default:   return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int W      = 12,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_s,
  input  logic [W-1:0] sense,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] clr,
  output logic [W-1:0] raw,
  output logic [W-1:0] hit
);
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= pin_s;
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic rise, fall, lvl_act;
    assign rise    = pin_s[i] & ~prev[i];
    assign fall    = ~pin_s[i] & prev[i];
    assign hit[i]  = pol[i] ? rise : fall;
    assign lvl_act = (pin_s[i] == pol[i]);

    always_ff @(posedge clk) begin
      if (rst)           raw[i] <= 1'b0;
      else if (sense[i]) raw[i] <= lvl_act;
      else               raw[i] <= hit[i] | (raw[i] & ~clr[i]);
    end
  end
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int W  = 12,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DW-1:0]     wdata,
  input  logic [W-1:0]      raw,
  output logic [W-1:0]      sense,
  output logic [W-1:0]      pol,
  output logic [W-1:0]      mask,
  output logic [W-1:0]      clr,
  output logic [DW-1:0]     rdata
);
  reg_sel_e     sel;
  logic [W-1:0] wbits;
  logic [W-1:0] rd_mux;
  logic         unused_whi;

  assign sel        = decode_off(addr);
  assign wbits      = wdata[W-1:0];
  assign unused_whi = ^wdata[DW-1:W];
  assign clr        = (we && sel == SEL_CLR) ? wbits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      sense <= '0;
      pol   <= '0;
      mask  <= '0;
    end else if (we) begin
      case (sel)
        SEL_SENSE: sense <= wbits;
        SEL_POL:   pol   <= wbits;
        SEL_MASK:  mask  <= wbits;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_SENSE: rd_mux = sense;
      SEL_POL:   rd_mux = pol;
      SEL_MASK:  rd_mux = mask;
      SEL_RAW:   rd_mux = raw;
      SEL_MSTAT: rd_mux = raw & mask;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= {{(DW-W){1'b0}}, rd_mux};
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NPINS       = 12,
  parameter int DW          = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPINS-1:0]  pin_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [NPINS-1:0]  pin_irq,
  output logic              port_irq
);
  logic [NPINS-1:0] pin_s, sense_r, pol_r, mask_r, clr_bits, raw_st, edge_hit;

  gpio_irq_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_s)
  );

  gpio_irq_detect #(.W(NPINS)) u_det (
    .clk(clk), .rst(rst), .pin_s(pin_s), .sense(sense_r), .pol(pol_r),
    .clr(clr_bits), .raw(raw_st), .hit(edge_hit)
  );

  gpio_irq_regs #(.W(NPINS), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .raw(raw_st), .sense(sense_r), .pol(pol_r), .mask(mask_r),
    .clr(clr_bits), .rdata(bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_irq  <= '0;
      port_irq <= 1'b0;
    end else begin
      pin_irq  <= raw_st & mask_r;
      port_irq <= |(raw_st & mask_r);
    end
  end
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 12,
  parameter int DW    = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DW-1:0]     bus_rdata,
  input logic [NPINS-1:0]  pin_irq,
  input logic              port_irq,
  input logic [NPINS-1:0]  raw,
  input logic [NPINS-1:0]  mask,
  input logic [NPINS-1:0]  sense,
  input logic [NPINS-1:0]  clr,
  input logic [NPINS-1:0]  hit
);
  AST_IRQ_MATCHES_MASKED: assert property (@(posedge clk) disable iff (rst) pin_irq == $past(raw & mask)) else $error("pin_irq mismatch"); // R7
  AST_PORT_IS_OR: assert property (@(posedge clk) disable iff (rst) port_irq == (|pin_irq)) else $error("port_irq mismatch"); // R8
  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (rst) bus_rdata[DW-1:NPINS] == '0) else $error("reserved bits set"); // R2
  AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (rst) ($past(raw & ~sense & ~clr) & ~raw) == '0) else $error("edge status lost"); // R5
  AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst) ($past(hit & clr & ~sense) & ~raw) == '0) else $error("clear beat edge"); // R10
  AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (rst) $past(bus_addr == OFF_CLR) |-> bus_rdata == '0) else $error("clear reg read nonzero"); // R11
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPINS(NPINS), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .pin_irq(pin_irq), .port_irq(port_irq), .raw(raw_st), .mask(mask_r),
  .sense(sense_r), .clr(clr_bits), .hit(edge_hit)
);

// File: tb/gpio_irq_ctrl_tb.sv
module gpio_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] pins = '0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [11:0] pin_irq;
  logic        port_irq;
  int n_cmp = 0;
  int n_bad = 0;

  always #5ns clk = ~clk;

  gpio_irq_ctrl u_dut (
    .clk(clk), .rst(rst), .pin_in(pins), .bus_addr(addr), .bus_we(we),
    .bus_wdata(wdata), .bus_rdata(rdata), .pin_irq(pin_irq), .port_irq(port_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0; addr = 8'h00;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata; addr = 8'h00;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h04, d); chk("R1 sense", d, 0);
    rd(8'h0C, d); chk("R1 pol", d, 0);
    rd(8'h10, d); chk("R1 mask", d, 0);
    rd(8'h14, d); chk("R1 raw", d, 0);
    rd(8'h18, d); chk("R1 mstat", d, 0);
    chk("R1 pin_irq", {20'b0, pin_irq}, 0);
    chk("R1 port_irq", {31'b0, port_irq}, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(8'h04, 32'hFFFF_F000); rd(8'h04, d); chk("R2 sense reserved", d, 32'h0);
    wr(8'h0C, 32'hA5A5_A5A5); rd(8'h0C, d); chk("R2 pol", d, 32'h5A5);
    wr(8'h10, 32'h1234_5678); rd(8'h10, d); chk("R2 mask", d, 32'h678);
    wr(8'h0C, 0); wr(8'h10, 0);
    wr(8'h14, 32'hFFFF_FFFF); wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h14, d); chk("R3 raw readonly", d, 0);
    rd(8'h18, d); chk("R3 mstat readonly", d, 0);
    rd(8'h04, d); chk("R3 sense untouched", d, 0);
    rd(8'h1C, d); chk("R11 clr reads zero", d, 0);
    rd(8'h08, d); chk("R11 unmapped zero", d, 0);
    wr(8'h10, 32'h0000_0ABC);
    @(negedge clk); addr = 8'h10;
    @(negedge clk); chk("R11 one-cycle read", rdata, 32'hABC); addr = 8'h04;
    @(negedge clk); chk("R11 follows address", rdata, 32'h0); addr = 8'h00;
    wr(8'h10, 0);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    wr(8'h0C, 32'h001);
    @(negedge clk); pins[0] = 1'b1; cyc(5);
    rd(8'h14, d); chk("R4 rising latched", d, 32'h001);
    chk("R7 masked off", {20'b0, pin_irq}, 0);
    pins[0] = 1'b0; cyc(5);
    rd(8'h14, d); chk("R5 stays after release", d, 32'h001);
    pins[1] = 1'b1; cyc(5);
    rd(8'h14, d); chk("R4 rising ignored pol0", d, 32'h001);
    pins[1] = 1'b0; cyc(5);
    rd(8'h14, d); chk("R4 falling latched", d, 32'h003);
    wr(8'h1C, 32'h002); cyc(1);
    rd(8'h14, d); chk("R5 selective clear", d, 32'h001);
    wr(8'h1C, 32'h001); cyc(1);
    rd(8'h14, d); chk("R5 clear all", d, 32'h000);
    wr(8'h0C, 0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(8'h0C, 32'h004); wr(8'h10, 32'h004);
    @(negedge clk); pins[2] = 1'b1;
    cyc(3); chk("R9 irq not before k+3", {20'b0, pin_irq}, 0);
    cyc(1); chk("R9 irq at k+3", {20'b0, pin_irq}, 32'h004);
    chk("R8 port_irq high", {31'b0, port_irq}, 1);
    rd(8'h18, d); chk("R7 masked status", d, 32'h004);
    wr(8'h10, 0); cyc(1);
    chk("R7 mask blocks", {20'b0, pin_irq}, 0);
    chk("R8 port_irq low", {31'b0, port_irq}, 0);
    rd(8'h14, d); chk("R7 raw unaffected by mask", d, 32'h004);
    pins[2] = 1'b0; wr(8'h1C, 32'h004); wr(8'h0C, 0); cyc(4);
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr(8'h04, 32'h008); wr(8'h0C, 32'h008); cyc(3);
    rd(8'h14, d); chk("R6 low inactive", d, 0);
    pins[3] = 1'b1; cyc(5);
    rd(8'h14, d); chk("R6 high active", d, 32'h008);
    wr(8'h1C, 32'h008); cyc(2);
    rd(8'h14, d); chk("R6 clear no effect", d, 32'h008);
    pins[3] = 1'b0; cyc(5);
    rd(8'h14, d); chk("R6 follows level", d, 0);
    wr(8'h0C, 0); cyc(2);
    rd(8'h14, d); chk("R6 low active pol0", d, 32'h008);
    wr(8'h04, 0); wr(8'h1C, 32'h008); cyc(2);
    rd(8'h14, d); chk("R6 back to edge cleared", d, 0);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    wr(8'h0C, 32'h010);
    @(negedge clk); pins[4] = 1'b1; cyc(5);
    pins[4] = 1'b0; cyc(5);
    rd(8'h14, d); chk("R10 pre-set", d, 32'h010);
    pins[4] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); addr = 8'h1C; wdata = 32'h010; we = 1'b1;
    @(negedge clk); we = 1'b0; addr = 8'h00;
    cyc(2);
    rd(8'h14, d); chk("R10 edge wins", d, 32'h010);
    wr(8'h1C, 32'h010); cyc(1);
    rd(8'h14, d); chk("R10 plain clear", d, 0);
    pins[4] = 1'b0; wr(8'h0C, 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_regs();
    t_edge();
    t_mask();
    t_level();
    t_collide();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule